// File: doc/BRIEF.md
# Keypad Controller Command Register Front End

This block is the register-facing side of a keypad and GPIO controller that sits behind a two-wire serial target. A byte-level shim in front of it has already turned the bus into three strobes: a transfer start, a written byte and a byte to be returned. In every transfer the first written byte selects a command. Any later written bytes are parameters to that command, numbered from zero. Read bytes return the response to the command currently held.

The block holds the configuration, interrupt status, error, active-time, debounce, keypad geometry, clock and the three 16-bit GPIO registers (pull, direction and mask). It checks each parameter against the rule for its command and records any violation in a sticky error register. It drives an active-low interrupt line. Once a command has taken all its parameters it is replaced by a retired code, so a stray extra byte is reported as a bad parameter instead of being written to a register a second time. A one-cycle flush pulse tells the neighbouring key FIFO to empty itself.

Top module: `kpc_cmd_regs`

## Requirements
- R1: After reset the block holds config 0x80, status 0x10, active time 125, debounce 3, keypad size 0x33, clock 0x08, error 0x00 and all GPIO registers 0x0000. The held command is the retired code 0xFF.
- R2: `irq_n_o` is low exactly when the status register is non-zero.
- R3: A start strobe sets the byte index to 0. The first written byte of a transfer is latched as the command. A read strobe updates `rd_data_o` on the next clock edge.
- R4: Reading status (0x82) returns the status on byte 0 and 0x00 on later bytes. If status bit 4 (not initialised) is clear, the read clears the status to 0. If bit 4 is set, the status is kept.
- R5: Each raised error ORs its bit into the error register: bit 0 for a bad parameter, bit 1 for an unknown command. It also sets status bit 3. Error bits stay set until hardware reset. The error register reads through command 0x8C.
- R6: Command 0x83 with parameter 0xAA restores the R1 values of config, status, active time, debounce, keypad size and clock. Any other parameter raises a bad-parameter error.
- R7: Commands 0x84 (pull), 0x85 (direction) and 0x86 (mask) take the low byte first, which also clears the high byte, and then the high byte. Direction reads back through 0x87 and mask through 0x88, low byte first.
- R8: A keypad-size write (0x90) stores its value. It raises a bad parameter if bits 3:0 are outside 3..12 or bits 7:4 are outside 3..8. A debounce write (0x8F) of 0 stores the value and raises a bad parameter.
- R9: A clock write (0x93) stores its value and raises a bad parameter when bits 1:0 are 01 or 10. A clock read (0x94) returns bits 7:2 of the clock with bits 1:0 forced to 10.
- R10: A config write (0x81) stores the value, clears the status register and pulses `fifo_flush_o` for one cycle. A config read (0x92) returns only bits 3:0.
- R11: The identity read (0x80) returns 0x00 on byte 0 and 0x04 on byte 1.
- R12: After its last parameter, a write command is retired to 0xFF. A parameter written under 0xFF raises a bad parameter and changes no register.
- R13: A write parameter or a read under an undefined command code raises an unknown-command error. Such a read returns 0x00, including a read made before any command has been latched. Latching an undefined code without a parameter raises nothing.
- R14: A `key_event_i` pulse sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start_i | input | 1 | Start of a bus transfer |
| wr_strobe_i | input | 1 | Written byte valid |
| wr_data_i | input | 8 | Written byte |
| rd_strobe_i | input | 1 | Response byte requested |
| key_event_i | input | 1 | Key FIFO accepted an event |
| rd_data_o | output | 8 | Response byte, valid the cycle after the read strobe |
| irq_n_o | output | 1 | Active-low interrupt |
| fifo_flush_o | output | 1 | One-cycle request to empty the key FIFO |
| cfg_o | output | 8 | Configuration register |
| act_time_o | output | 8 | Active-time register |
| debounce_o | output | 8 | Debounce register |
| kp_size_o | output | 8 | Keypad geometry register |
| clk_cfg_o | output | 8 | Clock configuration register |
| gpio_pull_o | output | 16 | GPIO pull selection |
| gpio_dir_o | output | 16 | GPIO direction |
| gpio_mask_o | output | 16 | GPIO mask/state |

## Verification
The hardest state to reach from the ports is status held in a known, clean condition. The not-initialised bit blocks read-to-clear, and errors are sticky, so a naive sequence leaves status bit 3 set for the rest of the run. The bench first issues a config write, which is the only way out of the not-initialised state. Before every parameter check it reads status to clear it, so each individual error shows up alone, both on `irq_n_o` and as status 0x08. The surplus-byte case needs the command retired in the middle of a transfer, so a third byte is sent inside the same transfer as a one-parameter write.

// File: rtl/kpc_pkg.sv
// Shared command codes, bit positions and register bundle for the
// keypad controller command front end.
package kpc_pkg;
    localparam logic [7:0] CMD_ID_RD    = 8'h80;
    localparam logic [7:0] CMD_CFG_WR   = 8'h81;
    localparam logic [7:0] CMD_STAT_RD  = 8'h82;
    localparam logic [7:0] CMD_SOFT_RST = 8'h83;
    localparam logic [7:0] CMD_PULL_WR  = 8'h84;
    localparam logic [7:0] CMD_DIR_WR   = 8'h85;
    localparam logic [7:0] CMD_MASK_WR  = 8'h86;
    localparam logic [7:0] CMD_DIR_RD   = 8'h87;
    localparam logic [7:0] CMD_MASK_RD  = 8'h88;
    localparam logic [7:0] CMD_ACT_WR   = 8'h8B;
    localparam logic [7:0] CMD_ERR_RD   = 8'h8C;
    localparam logic [7:0] CMD_ROT_RD   = 8'h8E;
    localparam logic [7:0] CMD_DEB_WR   = 8'h8F;
    localparam logic [7:0] CMD_SIZE_WR  = 8'h90;
    localparam logic [7:0] CMD_SIZE_RD  = 8'h91;
    localparam logic [7:0] CMD_CFG_RD   = 8'h92;
    localparam logic [7:0] CMD_CLK_WR   = 8'h93;
    localparam logic [7:0] CMD_CLK_RD   = 8'h94;
    localparam logic [7:0] CMD_RETIRED  = 8'hFF;

    localparam logic [7:0] SOFT_RST_KEY = 8'hAA;
    localparam logic [7:0] ID_HI_BYTE   = 8'h04;

    localparam int ST_KEY    = 0;
    localparam int ST_ERR    = 3;
    localparam int ST_NOINIT = 4;
    localparam int ER_BADPAR = 0;
    localparam int ER_UNKCMD = 1;

    localparam int KP_MIN     = 3;
    localparam int KP_ROW_MAX = 12;
    localparam int KP_COL_MAX = 8;

    localparam logic [7:0] RST_CFG    = 8'h80;
    localparam logic [7:0] RST_STATUS = 8'h10;
    localparam logic [7:0] RST_ACT    = 8'd125;
    localparam logic [7:0] RST_DEB    = 8'd3;
    localparam logic [7:0] RST_SIZE   = 8'h33;
    localparam logic [7:0] RST_CLK    = 8'h08;

    typedef struct packed {
        logic [7:0]  cfg;
        logic [7:0]  status;
        logic [7:0]  err;
        logic [7:0]  act;
        logic [7:0]  deb;
        logic [7:0]  size;
        logic [7:0]  clk;
        logic [15:0] pull;
        logic [15:0] dir;
        logic [15:0] mask;
    } kpc_regs_t;
endpackage

// File: rtl/kpc_xfer_seq.sv
// Transfer sequencer: counts bytes within a transfer and holds the
// current command. Assumes the shim never raises a start strobe in the
// same cycle as a byte strobe; if it does, the start takes priority and
// the byte is dropped.
module kpc_xfer_seq #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [7:0]       data_i,
    input  logic             retire_i,
    output logic [7:0]       cmd_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             cmd_phase_o,
    output logic             wr_par_o,
    output logic             rd_ok_o
);
    import kpc_pkg::*;

    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    assign cmd_phase_o = wr_i && !start_i && (idx_o == '0);
    assign wr_par_o    = wr_i && !start_i && (idx_o != '0);
    assign rd_ok_o     = rd_i && !start_i;

    // Byte index: cleared by start, advanced by any byte, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o <= '0;
        end else if (start_i) begin
            idx_o <= '0;
        end else if ((wr_i || rd_i) && idx_o != IDX_MAX) begin
            idx_o <= idx_o + 1'b1;
        end
    end

    // Command holder: latch on the first written byte, retire when done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o <= CMD_RETIRED;
        end else if (cmd_phase_o) begin
            cmd_o <= data_i;
        end else if (retire_i) begin
            cmd_o <= CMD_RETIRED;
        end
    end

    AST_IDX_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (idx_o == '0)); // R3
    AST_CMD_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_phase_o |=> (cmd_o == $past(data_i))); // R3
endmodule

// File: rtl/kpc_param_chk.sv
// Parameter checker: from the held command, the parameter index and the
// byte value, decides whether the parameter is legal, whether the
// command is known for writing, and whether this byte completes it.
// Purely combinational; outputs are meaningful only on a parameter byte.
module kpc_param_chk #(
    parameter int IDX_W = 4
) (
    input  logic [7:0]       cmd_i,
    input  logic [IDX_W-1:0] pidx_i,
    input  logic [7:0]       data_i,
    output logic             bad_par_o,
    output logic             unk_o,
    output logic             done_o
);
    import kpc_pkg::*;

    logic [3:0] rows;
    logic [3:0] cols;
    assign rows = data_i[3:0];
    assign cols = data_i[7:4];

    // Per-command legality and completion rule.
    always_comb begin
        bad_par_o = 1'b0;
        unk_o     = 1'b0;
        done_o    = 1'b0;
        case (cmd_i)
            CMD_CFG_WR, CMD_ACT_WR: done_o = 1'b1;
            CMD_SOFT_RST: begin
                done_o    = 1'b1;
                bad_par_o = (data_i != SOFT_RST_KEY);
            end
            CMD_PULL_WR, CMD_DIR_WR, CMD_MASK_WR: done_o = (pidx_i != '0);
            CMD_DEB_WR: begin
                done_o    = 1'b1;
                bad_par_o = (data_i == 8'h00);
            end
            CMD_SIZE_WR: begin
                done_o    = 1'b1;
                bad_par_o = (32'(rows) < KP_MIN) || (32'(rows) > KP_ROW_MAX) ||
                            (32'(cols) < KP_MIN) || (32'(cols) > KP_COL_MAX);
            end
            CMD_CLK_WR: begin
                done_o    = 1'b1;
                bad_par_o = data_i[1] ^ data_i[0];
            end
            CMD_RETIRED: bad_par_o = 1'b1;
            default:     unk_o     = 1'b1;
        endcase
    end
endmodule

// File: rtl/kpc_resp_mux.sv
// Response selector: forms the byte returned for a read from the held
// command and the byte index. Flags undefined read commands and status
// reads so the register block can raise errors and clear status.
module kpc_resp_mux #(
    parameter int IDX_W = 4
) (
    input  logic [7:0]         cmd_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  kpc_pkg::kpc_regs_t regs_i,
    output logic [7:0]         data_o,
    output logic               unk_o,
    output logic               stat_rd_o
);
    import kpc_pkg::*;

    logic first;
    logic second;
    assign first  = (idx_i == IDX_W'(0));
    assign second = (idx_i == IDX_W'(1));

    // Byte select per read command.
    always_comb begin
        data_o    = 8'h00;
        unk_o     = 1'b0;
        stat_rd_o = 1'b0;
        case (cmd_i)
            CMD_ID_RD:   data_o = second ? ID_HI_BYTE : 8'h00;
            CMD_STAT_RD: begin
                stat_rd_o = 1'b1;
                data_o    = first ? regs_i.status : 8'h00;
            end
            CMD_DIR_RD:  data_o = first ? regs_i.dir[7:0]  : (second ? regs_i.dir[15:8]  : 8'h00);
            CMD_MASK_RD: data_o = first ? regs_i.mask[7:0] : (second ? regs_i.mask[15:8] : 8'h00);
            CMD_ERR_RD:  data_o = regs_i.err;
            CMD_ROT_RD:  data_o = 8'h00;
            CMD_SIZE_RD: data_o = regs_i.size;
            CMD_CFG_RD:  data_o = {4'h0, regs_i.cfg[3:0]};
            CMD_CLK_RD:  data_o = {regs_i.clk[7:2], 2'b10};
            default:     unk_o  = 1'b1;
        endcase
    end
endmodule

// File: rtl/kpc_cmd_regs.sv
// Command register front end of a keypad/GPIO controller. Takes byte
// strobes from a serial-bus target shim, applies parameter writes to the
// register set, returns read responses one cycle after the strobe, keeps
// sticky error flags and drives an active-low interrupt from status.
// Assumes at most one of start/write/read strobes per cycle.
module kpc_cmd_regs #(
    parameter int IDX_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xfer_start_i,
    input  logic        wr_strobe_i,
    input  logic [7:0]  wr_data_i,
    input  logic        rd_strobe_i,
    input  logic        key_event_i,
    output logic [7:0]  rd_data_o,
    output logic        irq_n_o,
    output logic        fifo_flush_o,
    output logic [7:0]  cfg_o,
    output logic [7:0]  act_time_o,
    output logic [7:0]  debounce_o,
    output logic [7:0]  kp_size_o,
    output logic [7:0]  clk_cfg_o,
    output logic [15:0] gpio_pull_o,
    output logic [15:0] gpio_dir_o,
    output logic [15:0] gpio_mask_o
);
    import kpc_pkg::*;

    kpc_regs_t        q, n;
    logic [7:0]       cmd;
    logic [IDX_W-1:0] idx, pidx;
    logic             cmd_phase, wr_par, rd_ok;
    logic             bad_par, w_unk, done, retire;
    logic [7:0]       resp;
    logic             r_unk, stat_rd;
    logic [7:0]       err_set;
    logic             flush_d;

    assign pidx   = idx - 1'b1;
    assign retire = wr_par && done;

    kpc_xfer_seq #(.IDX_W(IDX_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start_i(xfer_start_i), .wr_i(wr_strobe_i),
        .rd_i(rd_strobe_i), .data_i(wr_data_i), .retire_i(retire),
        .cmd_o(cmd), .idx_o(idx), .cmd_phase_o(cmd_phase),
        .wr_par_o(wr_par), .rd_ok_o(rd_ok)
    );

    kpc_param_chk #(.IDX_W(IDX_W)) chk_i (
        .cmd_i(cmd), .pidx_i(pidx), .data_i(wr_data_i),
        .bad_par_o(bad_par), .unk_o(w_unk), .done_o(done)
    );

    kpc_resp_mux #(.IDX_W(IDX_W)) resp_i (
        .cmd_i(cmd), .idx_i(idx), .regs_i(q),
        .data_o(resp), .unk_o(r_unk), .stat_rd_o(stat_rd)
    );

    // Next register state: writes, status clear, errors, then key events.
    always_comb begin
        n       = q;
        flush_d = 1'b0;
        err_set = 8'h00;
        if (wr_par) begin
            case (cmd)
                CMD_CFG_WR: begin
                    n.cfg    = wr_data_i;
                    n.status = 8'h00;
                    flush_d  = 1'b1;
                end
                CMD_SOFT_RST: if (!bad_par) begin
                    n.cfg    = RST_CFG;
                    n.status = RST_STATUS;
                    n.act    = RST_ACT;
                    n.deb    = RST_DEB;
                    n.size   = RST_SIZE;
                    n.clk    = RST_CLK;
                end
                CMD_PULL_WR: if (pidx == '0) n.pull = {8'h00, wr_data_i};
                             else            n.pull[15:8] = wr_data_i;
                CMD_DIR_WR:  if (pidx == '0) n.dir = {8'h00, wr_data_i};
                             else            n.dir[15:8] = wr_data_i;
                CMD_MASK_WR: if (pidx == '0) n.mask = {8'h00, wr_data_i};
                             else            n.mask[15:8] = wr_data_i;
                CMD_ACT_WR:  n.act  = wr_data_i;
                CMD_DEB_WR:  n.deb  = wr_data_i;
                CMD_SIZE_WR: n.size = wr_data_i;
                CMD_CLK_WR:  n.clk  = wr_data_i;
                default: ;
            endcase
            err_set[ER_BADPAR] = bad_par;
            err_set[ER_UNKCMD] = w_unk;
        end
        if (rd_ok) begin
            if (r_unk) err_set[ER_UNKCMD] = 1'b1;
            if (stat_rd && !q.status[ST_NOINIT]) n.status = 8'h00;
        end
        if (err_set != 8'h00) begin
            n.err            = q.err | err_set;
            n.status[ST_ERR] = 1'b1;
        end
        if (key_event_i) n.status[ST_KEY] = 1'b1;
    end

    // Register set, response byte and flush pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q            <= '{cfg: RST_CFG, status: RST_STATUS, err: 8'h00,
                              act: RST_ACT, deb: RST_DEB, size: RST_SIZE,
                              clk: RST_CLK, pull: 16'h0, dir: 16'h0, mask: 16'h0};
            rd_data_o    <= 8'h00;
            fifo_flush_o <= 1'b0;
        end else begin
            q            <= n;
            fifo_flush_o <= flush_d;
            if (rd_ok) rd_data_o <= resp;
        end
    end

    assign irq_n_o     = (q.status == 8'h00);
    assign cfg_o       = q.cfg;
    assign act_time_o  = q.act;
    assign debounce_o  = q.deb;
    assign kp_size_o   = q.size;
    assign clk_cfg_o   = q.clk;
    assign gpio_pull_o = q.pull;
    assign gpio_dir_o  = q.dir;
    assign gpio_mask_o = q.mask;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.err & $past(q.err)) == $past(q.err))); // R5
    AST_ERR_FLAGS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err != $past(q.err)) |-> q.status[ST_ERR]); // R5
    AST_NOINIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && stat_rd && q.status[ST_NOINIT]) |=> q.status[ST_NOINIT]); // R4
    AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && stat_rd && !q.status[ST_NOINIT] && !key_event_i) |=> irq_n_o); // R4
    AST_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (cmd == CMD_RETIRED)); // R12
    AST_FLUSH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush_o |-> (q.status[7:1] == 7'h00)); // R10
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_par && cmd == CMD_SOFT_RST && wr_data_i == SOFT_RST_KEY && !key_event_i)
        |=> (q.status == RST_STATUS && q.cfg == RST_CFG)); // R6
endmodule

// File: tb/kpc_cmd_regs_tb_top.sv
// Directed bench for the command register front end.
module kpc_cmd_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start_i = 1'b0;
    logic        wr_strobe_i = 1'b0;
    logic [7:0]  wr_data_i = 8'h00;
    logic        rd_strobe_i = 1'b0;
    logic        key_event_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic        irq_n_o, fifo_flush_o;
    logic [7:0]  cfg_o, act_time_o, debounce_o, kp_size_o, clk_cfg_o;
    logic [15:0] gpio_pull_o, gpio_dir_o, gpio_mask_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    kpc_cmd_regs dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_start_i(xfer_start_i),
        .wr_strobe_i(wr_strobe_i), .wr_data_i(wr_data_i),
        .rd_strobe_i(rd_strobe_i), .key_event_i(key_event_i),
        .rd_data_o(rd_data_o), .irq_n_o(irq_n_o), .fifo_flush_o(fifo_flush_o),
        .cfg_o(cfg_o), .act_time_o(act_time_o), .debounce_o(debounce_o),
        .kp_size_o(kp_size_o), .clk_cfg_o(clk_cfg_o), .gpio_pull_o(gpio_pull_o),
        .gpio_dir_o(gpio_dir_o), .gpio_mask_o(gpio_mask_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic start_x();
        @(negedge clk); xfer_start_i = 1'b1;
        @(negedge clk); xfer_start_i = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); wr_strobe_i = 1'b1; wr_data_i = b;
        @(negedge clk); wr_strobe_i = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk); rd_strobe_i = 1'b1;
        @(negedge clk); rd_strobe_i = 1'b0;
        b = rd_data_o;
    endtask

    task automatic send_cmd(input logic [7:0] c, input int np,
                            input logic [7:0] p0, input logic [7:0] p1);
        start_x();
        wr_byte(c);
        if (np > 0) wr_byte(p0);
        if (np > 1) wr_byte(p1);
    endtask

    task automatic read_cmd(input logic [7:0] c, output logic [7:0] d0, output logic [7:0] d1);
        start_x();
        wr_byte(c);
        start_x();
        rd_byte(d0);
        rd_byte(d1);
    endtask

    // Clears status (not-initialised already gone) and confirms the line is idle.
    task automatic clear_status(input string req);
        logic [7:0] a, b;
        read_cmd(8'h82, a, b);
        chk(req, {15'h0, irq_n_o}, 16'h1);
    endtask

    // After one parameter op: expect status 0x08 if bad, idle line otherwise.
    task automatic expect_bad(input string req, input bit bad);
        logic [7:0] a, b;
        chk(req, {15'h0, irq_n_o}, {15'h0, !bad});
        if (bad) begin
            read_cmd(8'h82, a, b);
            chk(req, {8'h0, a}, 16'h0008);
        end
    endtask

    task automatic t_reset();
        logic [7:0] a, b;
        chk("R1 cfg", {8'h0, cfg_o}, 16'h0080);
        chk("R1 act", {8'h0, act_time_o}, 16'd125);
        chk("R1 deb", {8'h0, debounce_o}, 16'd3);
        chk("R1 size", {8'h0, kp_size_o}, 16'h0033);
        chk("R1 clk", {8'h0, clk_cfg_o}, 16'h0008);
        chk("R1 gpio", gpio_dir_o | gpio_pull_o | gpio_mask_o, 16'h0);
        chk("R2 irq low at reset", {15'h0, irq_n_o}, 16'h0);
        // R13 read before any command latched
        start_x();
        rd_byte(a);
        chk("R13 no-cmd read", {8'h0, a}, 16'h0);
        read_cmd(8'h8C, a, b);
        chk("R13 unknown flag", {8'h0, a}, 16'h0002);
        read_cmd(8'h82, a, b);
        chk("R4 status noinit+err", {8'h0, a}, 16'h0018);
        chk("R4 status byte1", {8'h0, b}, 16'h0);
        read_cmd(8'h82, a, b);
        chk("R4 noinit kept", {8'h0, a}, 16'h0018);
        chk("R2 irq still low", {15'h0, irq_n_o}, 16'h0);
    endtask

    task automatic t_config();
        logic [7:0] a, b;
        send_cmd(8'h81, 1, 8'hF5, 8'h00);
        chk("R10 flush pulse", {15'h0, fifo_flush_o}, 16'h1);
        chk("R10 status cleared", {15'h0, irq_n_o}, 16'h1);
        chk("R10 cfg stored", {8'h0, cfg_o}, 16'h00F5);
        @(negedge clk);
        chk("R10 flush one cycle", {15'h0, fifo_flush_o}, 16'h0);
        // R12 surplus byte in the same transfer
        wr_byte(8'h33);
        chk("R12 cfg unchanged", {8'h0, cfg_o}, 16'h00F5);
        read_cmd(8'h8C, a, b);
        chk("R12 badpar sticky R5", {8'h0, a}, 16'h0003);
        read_cmd(8'h82, a, b);
        chk("R12 status err", {8'h0, a}, 16'h0008);
        chk("R4 cleared by read", {15'h0, irq_n_o}, 16'h1);
        read_cmd(8'h82, a, b);
        chk("R4 second read zero", {8'h0, a}, 16'h0);
        read_cmd(8'h92, a, b);
        chk("R10 cfg low nibble", {8'h0, a}, 16'h0005);
    endtask

    task automatic t_id();
        logic [7:0] a, b;
        read_cmd(8'h80, a, b);
        chk("R11 id byte0", {8'h0, a}, 16'h0);
        chk("R11 id byte1", {8'h0, b}, 16'h0004);
        chk("R11 no error", {15'h0, irq_n_o}, 16'h1);
    endtask

    task automatic t_gpio();
        logic [7:0] a, b;
        send_cmd(8'h85, 2, 8'h34, 8'h12);
        chk("R7 dir", gpio_dir_o, 16'h1234);
        read_cmd(8'h87, a, b);
        chk("R7 dir readback", {a, b}, 16'h3412);
        send_cmd(8'h84, 2, 8'hAB, 8'hCD);
        chk("R7 pull", gpio_pull_o, 16'hCDAB);
        send_cmd(8'h86, 2, 8'h0F, 8'hF0);
        read_cmd(8'h88, a, b);
        chk("R7 mask readback", {a, b}, 16'h0FF0);
        send_cmd(8'h85, 1, 8'h77, 8'h00);
        chk("R7 low byte clears high", gpio_dir_o, 16'h0077);
        chk("R7 no error", {15'h0, irq_n_o}, 16'h1);
    endtask

    task automatic t_limits();
        logic [7:0] a, b;
        clear_status("R8 pre");
        send_cmd(8'h90, 1, 8'h2C, 8'h00);
        chk("R8 size stored", {8'h0, kp_size_o}, 16'h002C);
        expect_bad("R8 cols 2", 1'b1);
        send_cmd(8'h90, 1, 8'h8C, 8'h00);
        expect_bad("R8 size 8x12 ok", 1'b0);
        send_cmd(8'h90, 1, 8'h3D, 8'h00);
        expect_bad("R8 rows 13", 1'b1);
        send_cmd(8'h90, 1, 8'h93, 8'h00);
        expect_bad("R8 cols 9", 1'b1);
        send_cmd(8'h90, 1, 8'h33, 8'h00);
        expect_bad("R8 size 3x3 ok", 1'b0);
        read_cmd(8'h91, a, b);
        chk("R8 size readback", {8'h0, a}, 16'h0033);
        send_cmd(8'h8F, 1, 8'h00, 8'h00);
        chk("R8 deb stored", {8'h0, debounce_o}, 16'h0);
        expect_bad("R8 deb zero", 1'b1);
        send_cmd(8'h8F, 1, 8'h05, 8'h00);
        expect_bad("R8 deb ok", 1'b0);
        send_cmd(8'h8B, 1, 8'h40, 8'h00);
        chk("R12 act stored", {8'h0, act_time_o}, 16'h0040);
    endtask

    task automatic t_clock();
        logic [7:0] a, b;
        send_cmd(8'h93, 1, 8'h05, 8'h00);
        expect_bad("R9 clk 01", 1'b1);
        send_cmd(8'h93, 1, 8'hFB, 8'h00);
        expect_bad("R9 clk 11 ok", 1'b0);
        read_cmd(8'h94, a, b);
        chk("R9 clk read", {8'h0, a}, 16'h00FA);
        send_cmd(8'h93, 1, 8'h02, 8'h00);
        expect_bad("R9 clk 10", 1'b1);
        send_cmd(8'h93, 1, 8'h00, 8'h00);
        expect_bad("R9 clk 00 ok", 1'b0);
        read_cmd(8'h94, a, b);
        chk("R9 clk read low", {8'h0, a}, 16'h0002);
    endtask

    task automatic t_soft_reset();
        logic [7:0] a, b;
        send_cmd(8'h83, 1, 8'h55, 8'h00);
        chk("R6 bad key keeps act", {8'h0, act_time_o}, 16'h0040);
        expect_bad("R6 bad key", 1'b1);
        send_cmd(8'h83, 1, 8'hAA, 8'h00);
        chk("R6 cfg", {8'h0, cfg_o}, 16'h0080);
        chk("R6 act", {8'h0, act_time_o}, 16'd125);
        chk("R6 clk", {8'h0, clk_cfg_o}, 16'h0008);
        read_cmd(8'h82, a, b);
        chk("R6 status noinit", {8'h0, a}, 16'h0010);
        send_cmd(8'h81, 1, 8'h00, 8'h00);
        chk("R10 leaves noinit", {15'h0, irq_n_o}, 16'h1);
    endtask

    task automatic t_unknown();
        logic [7:0] a, b;
        start_x();
        wr_byte(8'hA0);
        chk("R13 latch only no error", {15'h0, irq_n_o}, 16'h1);
        wr_byte(8'h11);
        expect_bad("R13 unknown write", 1'b1);
        read_cmd(8'hA0, a, b);
        chk("R13 unknown read zero", {8'h0, a}, 16'h0);
        expect_bad("R13 unknown read", 1'b1);
        send_cmd(8'hFF, 1, 8'h00, 8'h00);
        expect_bad("R12 retired write", 1'b1);
        read_cmd(8'h8C, a, b);
        chk("R5 error bits", {8'h0, a}, 16'h0003);
    endtask

    task automatic t_key();
        logic [7:0] a, b;
        @(negedge clk); key_event_i = 1'b1;
        @(negedge clk); key_event_i = 1'b0;
        chk("R14 irq on key", {15'h0, irq_n_o}, 16'h0);
        read_cmd(8'h82, a, b);
        chk("R14 key bit", {8'h0, a}, 16'h0001);
        chk("R2 irq released", {15'h0, irq_n_o}, 16'h1);
        start_x();
        chk("R3 start alone no change", {15'h0, irq_n_o}, 16'h1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_id();
        t_gpio();
        t_limits();
        t_clock();
        t_soft_reset();
        t_unknown();
        t_key();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule